// File: doc/BRIEF.md
# DSI Link Power State Controller

This block steps a DSI host link through its four power states: the initial state after reset, the low-power stop state, the state with the high-speed clock running, and ultra-low-power. Its client issues one command at a time: bring the link up, turn on the high-speed clock, choose high-speed or low-power transfer, or enter and leave ultra-low-power. Each command produces exactly one ok or error pulse.

Bringing the link up is the only command that takes more than one cycle. The block loads the lane enable mask from the configured data lane count, pulses the FIFO pointer reset and the interrupt-status clear, and turns on the PLL. It then checks the PLL-stable input once per cycle up to a parameterised limit. After that it checks the lane stop-state input once per cycle up to a second limit. If either limit runs out, the block clears the lanes and the PLL and stays in the initial state. Commands that arrive while this sequence runs are dropped.

Top module: `dsi_link_pwr_ctrl`

## Requirements
- R1: After reset, link_state is 0 (initial), busy, both response pulses, fifo_ptr_rst, irq_clr, pll_en, hs_clk_en, both transfer-path outputs and every lane_en bit are 0.
- R2: link_state encodes initial=0, stop=1, high-speed clock on=2, ultra-low-power=3. In lane_en, bit 0 is the clock lane and bit k+1 is data lane k. A lane count n from 1 to NUM_DATA_LANES sets bit 0 and bits 1 through n, and no other bits.
- R3: A link-up command (op 0) in the initial state with a lane count of 0 or above NUM_DATA_LANES returns an error pulse one cycle after acceptance. The state stays initial, lane_en stays 0, pll_en stays 0, and no FIFO reset pulse is issued.
- R4: A valid link-up command in the initial state causes, in the cycle after acceptance, a one-cycle fifo_ptr_rst pulse and a one-cycle irq_clr pulse. In that same cycle pll_en goes to 1, lane_en takes the decoded mask, and busy goes to 1.
- R5: pll_stable is sampled once per clock, starting on the edge after acceptance, for at most PLL_TRIES samples. If none of them is high, an error pulse follows the last sample and pll_en and lane_en return to 0 with the state left at initial.
- R6: After the first high PLL sample, lanes_stopped is sampled once per clock for at most STOP_TRIES samples. The first high sample moves the state to stop with an ok pulse. If no sample is high, the block returns an error pulse and backs out as in R5.
- R7: A link-up command in any state other than initial returns ok one cycle after acceptance and changes no output.
- R8: The high-speed clock command (op 1) is accepted only in stop with cfg_clk_bypass low. It moves the state to 2, sets hs_clk_en and both transfer-path outputs, and returns ok. Anywhere else it returns an error and changes nothing.
- R9: The high-speed transfer command (op 2) is legal only in state 2 and sets both transfer paths to 1. The low-power transfer command (op 3) is legal in stop or state 2 and clears both paths. Either command in any other state returns an error with no change.
- R10: The ultra-low-power entry command (op 4), from stop or state 2, moves the state to 3 and clears hs_clk_en and both paths. The exit command (op 5) is legal only in state 3 and returns the state to stop. Misplaced entry or exit commands return an error with no change.
- R11: Every accepted command yields exactly one response pulse, and ok and error are never high together. A non-sequencing command responds one cycle after acceptance. A command presented while busy is high is not accepted and produces no response.
- R12: Op codes 6 and 7 return an error pulse one cycle after acceptance and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; accepted when busy is low |
| cmd_op | input | 3 | Command code (0 link-up, 1 HS clock on, 2 HS transfer, 3 LP transfer, 4 ULP enter, 5 ULP exit) |
| cfg_lane_cnt | input | $clog2(NUM_DATA_LANES+1) | Configured number of data lanes |
| cfg_clk_bypass | input | 1 | Byte clock taken from external bypass source |
| pll_stable | input | 1 | PLL lock indication |
| lanes_stopped | input | 1 | All enabled lanes in stop state |
| busy | output | 1 | Link-up sequence in progress |
| rsp_ok | output | 1 | One-cycle success response |
| rsp_err | output | 1 | One-cycle error response |
| link_state | output | 2 | Current link state |
| lane_en | output | NUM_DATA_LANES+1 | Lane enable mask |
| fifo_ptr_rst | output | 1 | One-cycle FIFO pointer reset |
| irq_clr | output | 1 | One-cycle interrupt-status clear |
| pll_en | output | 1 | PLL enable |
| hs_clk_en | output | 1 | High-speed clock lane enable |
| vid_path_hs | output | 1 | Video path uses high-speed transfer |
| cmd_path_hs | output | 1 | Command path uses high-speed transfer |

## Verification
The hardest cases to reach are the poll limits. The bench must make the PLL or the lanes succeed on exactly the last allowed sample, or fail on it, and it must present a command while the link-up sequence is still running. To do this, the stimulus counts clock edges from the acceptance edge and drives pll_stable and lanes_stopped low for a chosen number of samples. Some delays are set at or beyond each limit, and a stray command is injected on the second sequence edge. Random command streams, with occasional resets back to the initial state, check every command against every state.

// File: rtl/dsi_link_pwr_pkg.sv
package dsi_link_pwr_pkg;

   localparam int OP_W = 3;

   typedef enum logic [1:0] {
      LS_INIT  = 2'd0,
      LS_STOP  = 2'd1,
      LS_HSCLK = 2'd2,
      LS_ULPS  = 2'd3
   } link_state_e;

   typedef enum logic [OP_W-1:0] {
      OP_LINK_UP    = 3'd0,
      OP_HS_CLK_ON  = 3'd1,
      OP_XFER_HS    = 3'd2,
      OP_XFER_LP    = 3'd3,
      OP_ULPS_ENTER = 3'd4,
      OP_ULPS_EXIT  = 3'd5
   } link_op_e;

   // Decision for one command in the current state
   typedef struct packed {
      logic        ok;          // legal, immediate ok response
      logic        start_seq;   // launch the link-up sequence instead
      logic        upd_state;
      link_state_e new_state;
      logic        upd_clk;
      logic        clk_val;
      logic        upd_path;
      logic        path_val;
   } cmd_verdict_t;

endpackage

// File: rtl/dsi_lane_mask_dec.sv
module dsi_lane_mask_dec #(
   parameter  int NUM_DATA_LANES = 4,
   localparam int LANE_W = NUM_DATA_LANES + 1,
   localparam int LCNT_W = $clog2(NUM_DATA_LANES + 1)
)(
   input  logic [LCNT_W-1:0] lane_cnt,
   output logic [LANE_W-1:0] mask,
   output logic              valid
);

   generate
      if (NUM_DATA_LANES < 1 || NUM_DATA_LANES > 8) begin : g_bad_lanes
         $error("NUM_DATA_LANES must lie in 1..8");
      end
   endgenerate

   // clock lane always on when any lane is enabled
   assign mask[0] = 1'b1;

   generate
      for (genvar i = 0; i < NUM_DATA_LANES; i++) begin : g_data_lane
         assign mask[i+1] = (lane_cnt > LCNT_W'(i));
      end
   endgenerate

   assign valid = (lane_cnt != '0) && (lane_cnt <= LCNT_W'(NUM_DATA_LANES));

endmodule

// File: rtl/dsi_bounded_poll.sv
module dsi_bounded_poll #(
   parameter  int TRIES = 100,
   localparam int CW    = $clog2(TRIES + 1)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic cond,
   output logic active,
   output logic pass,
   output logic expire
);

   generate
      if (TRIES < 1) begin : g_bad_tries
         $error("TRIES must be at least 1");
      end
   endgenerate

   logic          act_q;
   logic [CW-1:0] cnt_q;

   // one sample per cycle while active; cnt_q counts samples already failed
   assign active = act_q;
   assign pass   = act_q & cond;
   assign expire = act_q & ~cond & (cnt_q == CW'(TRIES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (arm) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end else if (pass || expire) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (act_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/dsi_cmd_gate.sv
module dsi_cmd_gate
   import dsi_link_pwr_pkg::*;
(
   input  logic [OP_W-1:0] op,
   input  link_state_e     cur,
   input  logic            clk_bypass,
   input  logic            lanes_ok,
   output cmd_verdict_t    verdict
);

   always_comb begin
      verdict           = '0;
      verdict.new_state = cur;
      case (op)
         OP_LINK_UP: begin
            if (cur == LS_INIT) begin
               verdict.start_seq = lanes_ok;
               verdict.ok        = 1'b0;
            end else begin
               verdict.ok = 1'b1;
            end
         end
         OP_HS_CLK_ON: begin
            if (cur == LS_STOP && !clk_bypass) begin
               verdict.ok        = 1'b1;
               verdict.upd_state = 1'b1;
               verdict.new_state = LS_HSCLK;
               verdict.upd_clk   = 1'b1;
               verdict.clk_val   = 1'b1;
               verdict.upd_path  = 1'b1;
               verdict.path_val  = 1'b1;
            end
         end
         OP_XFER_HS: begin
            if (cur == LS_HSCLK) begin
               verdict.ok       = 1'b1;
               verdict.upd_path = 1'b1;
               verdict.path_val = 1'b1;
            end
         end
         OP_XFER_LP: begin
            if (cur == LS_STOP || cur == LS_HSCLK) begin
               verdict.ok       = 1'b1;
               verdict.upd_path = 1'b1;
               verdict.path_val = 1'b0;
            end
         end
         OP_ULPS_ENTER: begin
            if (cur == LS_STOP || cur == LS_HSCLK) begin
               verdict.ok        = 1'b1;
               verdict.upd_state = 1'b1;
               verdict.new_state = LS_ULPS;
               verdict.upd_clk   = 1'b1;
               verdict.clk_val   = 1'b0;
               verdict.upd_path  = 1'b1;
               verdict.path_val  = 1'b0;
            end
         end
         OP_ULPS_EXIT: begin
            if (cur == LS_ULPS) begin
               verdict.ok        = 1'b1;
               verdict.upd_state = 1'b1;
               verdict.new_state = LS_STOP;
            end
         end
         default: verdict.ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/dsi_link_pwr_ctrl.sv
module dsi_link_pwr_ctrl
   import dsi_link_pwr_pkg::*;
#(
   parameter  int NUM_DATA_LANES = 4,
   parameter  int PLL_TRIES      = 1000,
   parameter  int STOP_TRIES     = 100,
   localparam int LANE_W         = NUM_DATA_LANES + 1,
   localparam int LCNT_W         = $clog2(NUM_DATA_LANES + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [OP_W-1:0]   cmd_op,
   input  logic [LCNT_W-1:0] cfg_lane_cnt,
   input  logic              cfg_clk_bypass,
   input  logic              pll_stable,
   input  logic              lanes_stopped,
   output logic              busy,
   output logic              rsp_ok,
   output logic              rsp_err,
   output logic [1:0]        link_state,
   output logic [LANE_W-1:0] lane_en,
   output logic              fifo_ptr_rst,
   output logic              irq_clr,
   output logic              pll_en,
   output logic              hs_clk_en,
   output logic              vid_path_hs,
   output logic              cmd_path_hs
);

   generate
      if (PLL_TRIES < 1 || STOP_TRIES < 1) begin : g_bad_limits
         $error("poll limits must be at least 1");
      end
   endgenerate

   link_state_e       state_q;
   logic [LANE_W-1:0] lane_en_q;
   logic              pll_en_q, hs_clk_q, vid_hs_q, cmd_hs_q;
   logic              fifo_rst_q, irq_clr_q, rsp_ok_q, rsp_err_q;

   logic [LANE_W-1:0] dec_mask;
   logic              dec_ok;
   cmd_verdict_t      vd;
   logic              accept, seq_go;
   logic              pll_act, pll_pass, pll_expire;
   logic              lane_act, lane_pass, lane_expire;

   dsi_lane_mask_dec #(.NUM_DATA_LANES(NUM_DATA_LANES)) u_mask (
      .lane_cnt (cfg_lane_cnt),
      .mask     (dec_mask),
      .valid    (dec_ok)
   );

   dsi_cmd_gate u_gate (
      .op         (cmd_op),
      .cur        (state_q),
      .clk_bypass (cfg_clk_bypass),
      .lanes_ok   (dec_ok),
      .verdict    (vd)
   );

   assign busy   = pll_act | lane_act;
   assign accept = cmd_valid & ~busy;
   assign seq_go = accept & vd.start_seq;

   // PLL lock wait, then lane stop-state wait
   dsi_bounded_poll #(.TRIES(PLL_TRIES)) u_pll_poll (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (seq_go),
      .cond   (pll_stable),
      .active (pll_act),
      .pass   (pll_pass),
      .expire (pll_expire)
   );

   dsi_bounded_poll #(.TRIES(STOP_TRIES)) u_lane_poll (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (pll_pass),
      .cond   (lanes_stopped),
      .active (lane_act),
      .pass   (lane_pass),
      .expire (lane_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= LS_INIT;
         lane_en_q  <= '0;
         pll_en_q   <= 1'b0;
         hs_clk_q   <= 1'b0;
         vid_hs_q   <= 1'b0;
         cmd_hs_q   <= 1'b0;
         fifo_rst_q <= 1'b0;
         irq_clr_q  <= 1'b0;
         rsp_ok_q   <= 1'b0;
         rsp_err_q  <= 1'b0;
      end else begin
         fifo_rst_q <= 1'b0;
         irq_clr_q  <= 1'b0;
         rsp_ok_q   <= 1'b0;
         rsp_err_q  <= 1'b0;
         if (accept) begin
            if (vd.start_seq) begin
               lane_en_q  <= dec_mask;
               pll_en_q   <= 1'b1;
               fifo_rst_q <= 1'b1;
               irq_clr_q  <= 1'b1;
            end else begin
               rsp_ok_q  <= vd.ok;
               rsp_err_q <= ~vd.ok;
               if (vd.ok) begin
                  if (vd.upd_state) state_q  <= vd.new_state;
                  if (vd.upd_clk)   hs_clk_q <= vd.clk_val;
                  if (vd.upd_path) begin
                     vid_hs_q <= vd.path_val;
                     cmd_hs_q <= vd.path_val;
                  end
               end
            end
         end
         if (pll_expire || lane_expire) begin
            rsp_err_q <= 1'b1;
            pll_en_q  <= 1'b0;
            lane_en_q <= '0;
         end
         if (lane_pass) begin
            state_q  <= LS_STOP;
            rsp_ok_q <= 1'b1;
         end
      end
   end

   assign link_state   = state_q;
   assign lane_en      = lane_en_q;
   assign pll_en       = pll_en_q;
   assign hs_clk_en    = hs_clk_q;
   assign vid_path_hs  = vid_hs_q;
   assign cmd_path_hs  = cmd_hs_q;
   assign fifo_ptr_rst = fifo_rst_q;
   assign irq_clr      = irq_clr_q;
   assign rsp_ok       = rsp_ok_q;
   assign rsp_err      = rsp_err_q;

endmodule

// File: rtl/dsi_link_pwr_ctrl_chk.sv
module dsi_link_pwr_ctrl_chk
   import dsi_link_pwr_pkg::*;
#(
   parameter  int NUM_DATA_LANES = 4,
   parameter  int PLL_TRIES      = 1000,
   parameter  int STOP_TRIES     = 100,
   localparam int LANE_W         = NUM_DATA_LANES + 1,
   localparam int RUN_MAX        = PLL_TRIES + STOP_TRIES,
   localparam int RUN_W          = $clog2(RUN_MAX + 2)
)(
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              rsp_ok,
   input logic              rsp_err,
   input logic [1:0]        link_state,
   input logic [LANE_W-1:0] lane_en,
   input logic              fifo_ptr_rst,
   input logic              irq_clr,
   input logic              pll_en,
   input logic              hs_clk_en,
   input logic              vid_path_hs,
   input logic              cmd_path_hs
);

   logic [RUN_W-1:0]  busy_run;
   logic [LANE_W-2:0] data_bits;

   assign data_bits = lane_en[LANE_W-1:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else           busy_run <= '0;
   end

   assert_one_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rsp_ok, rsp_err}) <= 1);

   assert_state_moves_on_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state != $past(link_state)) |-> rsp_ok);

   assert_lane_mask_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_en) |-> (lane_en[0] && lane_en[1] && ((data_bits & (data_bits + 1'b1)) == '0)));

   assert_seq_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ptr_rst |-> (irq_clr && pll_en && busy && link_state == 2'(LS_INIT)));

   assert_pll_drop_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_en) |-> (rsp_err && lane_en == '0));

   assert_stop_after_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(link_state) == 2'(LS_INIT) && link_state == 2'(LS_STOP)) |-> (rsp_ok && $past(busy)));

   assert_poll_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= RUN_W'(RUN_MAX));

   assert_hs_entry_from_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == 2'(LS_HSCLK) && $past(link_state) != 2'(LS_HSCLK))
         |-> ($past(link_state) == 2'(LS_STOP) && hs_clk_en));

   assert_hs_path_needs_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_path_hs || cmd_path_hs) |-> (link_state == 2'(LS_HSCLK)));

   assert_ulps_clk_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (link_state == 2'(LS_ULPS)) |-> !hs_clk_en);

endmodule

bind dsi_link_pwr_ctrl dsi_link_pwr_ctrl_chk #(
   .NUM_DATA_LANES (NUM_DATA_LANES),
   .PLL_TRIES      (PLL_TRIES),
   .STOP_TRIES     (STOP_TRIES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .rsp_ok       (rsp_ok),
   .rsp_err      (rsp_err),
   .link_state   (link_state),
   .lane_en      (lane_en),
   .fifo_ptr_rst (fifo_ptr_rst),
   .irq_clr      (irq_clr),
   .pll_en       (pll_en),
   .hs_clk_en    (hs_clk_en),
   .vid_path_hs  (vid_path_hs),
   .cmd_path_hs  (cmd_path_hs)
);

// File: tb/dsi_link_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module dsi_link_pwr_ctrl_tb_top;

   localparam int NL    = 4;
   localparam int PLLT  = 1000;
   localparam int STOPT = 100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [2:0] cfg_lane_cnt = '0;
   logic       cfg_clk_bypass = 1'b0;
   logic       pll_stable = 1'b0;
   logic       lanes_stopped = 1'b0;
   logic       busy, rsp_ok, rsp_err, fifo_ptr_rst, irq_clr, pll_en, hs_clk_en;
   logic       vid_path_hs, cmd_path_hs;
   logic [1:0] link_state;
   logic [4:0] lane_en;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;

   // bench model of the visible state
   int       m_state;
   bit [4:0] m_lane;
   bit       m_pll, m_hs, m_path;

   always #2 clk = ~clk;

   dsi_link_pwr_ctrl #(.NUM_DATA_LANES(NL), .PLL_TRIES(PLLT), .STOP_TRIES(STOPT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cfg_lane_cnt(cfg_lane_cnt), .cfg_clk_bypass(cfg_clk_bypass),
      .pll_stable(pll_stable), .lanes_stopped(lanes_stopped),
      .busy(busy), .rsp_ok(rsp_ok), .rsp_err(rsp_err), .link_state(link_state),
      .lane_en(lane_en), .fifo_ptr_rst(fifo_ptr_rst), .irq_clr(irq_clr),
      .pll_en(pll_en), .hs_clk_en(hs_clk_en), .vid_path_hs(vid_path_hs),
      .cmd_path_hs(cmd_path_hs));

   always @(posedge clk) begin
      cyc++;
      if (cyc == 180000) begin
         miscompares++;
         $display("FAIL watchdog: act cycle %0d exp completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: act %0h exp %0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic bit [4:0] exp_mask(input int cnt);
      bit [4:0] m = 5'b00001;
      for (int i = 0; i < NL; i++) if (i < cnt) m[i+1] = 1'b1;
      return m;
   endfunction

   function automatic bit [10:0] model_snap();
      return {2'(m_state), m_lane, m_pll, m_hs, m_path, m_path};
   endfunction

   function automatic bit [10:0] dut_snap();
      return {link_state, lane_en, pll_en, hs_clk_en, vid_path_hs, cmd_path_hs};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cmd_valid = 1'b0;
      m_state = 0; m_lane = '0; m_pll = 0; m_hs = 0; m_path = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // immediate-response legality, computed from the requirements
   task automatic model_simple(input int op, input bit byp, output bit ok);
      ok = 0;
      case (op)
         0: ok = (m_state != 0);                                                   // R7
         1: if (m_state == 1 && !byp) begin ok = 1; m_state = 2; m_hs = 1; m_path = 1; end // R8
         2: if (m_state == 2) begin ok = 1; m_path = 1; end                        // R9
         3: if (m_state == 1 || m_state == 2) begin ok = 1; m_path = 0; end        // R9
         4: if (m_state == 1 || m_state == 2) begin ok = 1; m_state = 3; m_hs = 0; m_path = 0; end // R10
         5: if (m_state == 3) begin ok = 1; m_state = 1; end                       // R10
         default: ok = 0;                                                          // R12
      endcase
   endtask

   task automatic do_cmd(input int op, input int cnt, input bit byp, input int pd, input int ld,
                         input string req);
      bit seq, ok;
      int kexp, kgot;
      bit eok;
      bit [4:0] mask;
      seq  = (op == 0 && m_state == 0 && cnt >= 1 && cnt <= NL);
      mask = exp_mask(cnt);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(op); cfg_lane_cnt = 3'(cnt); cfg_clk_bypass = byp;
      pll_stable = 1'b0; lanes_stopped = 1'b0;
      @(posedge clk); #1;
      if (!seq) begin
         if (op == 0 && m_state == 0) ok = 0;   // R3 invalid lane count
         else model_simple(op, byp, ok);
         check({req, " response"}, {30'd0, rsp_ok, rsp_err}, {30'd0, ok, !ok});
         check({req, " state/outputs"}, 32'(dut_snap()), 32'(model_snap()));
         check("R11 no busy for immediate command", 32'(busy), 0);
         if (op == 0 && m_state == 0)
            check("R3 no FIFO reset on bad lane count", 32'(fifo_ptr_rst), 0);
         @(negedge clk);
         cmd_valid = 1'b0;
         return;
      end
      check("R4 start pulses/pll/busy", {28'd0, fifo_ptr_rst, irq_clr, pll_en, busy}, 32'hF);
      check("R2 lane mask", 32'(lane_en), 32'(mask));
      check("R4 no early response", {30'd0, rsp_ok, rsp_err}, 0);
      if (pd >= PLLT) begin kexp = PLLT; eok = 0; end
      else if (ld >= STOPT) begin kexp = pd + 1 + STOPT; eok = 0; end
      else begin kexp = pd + 2 + ld; eok = 1; end
      kgot = -1;
      for (int k = 1; k <= PLLT + STOPT + 4; k++) begin
         @(negedge clk);
         cmd_valid = (k == 2);          // stray command while busy (R11)
         cmd_op = 3'd4;
         pll_stable = (k > pd);
         lanes_stopped = ((k - pd - 1) > ld);
         @(posedge clk); #1;
         if (k == 1) check("R4 one-cycle pulses", {30'd0, fifo_ptr_rst, irq_clr}, 0);
         if (rsp_ok || rsp_err) begin kgot = k; break; end
      end
      check(eok ? "R6 ok latency" : (pd >= PLLT ? "R5 error latency" : "R6 error latency"),
            32'(kgot), 32'(kexp));
      check(eok ? "R6 ok response" : "R5/R6 error response", {30'd0, rsp_ok, rsp_err},
            {30'd0, eok, !eok});
      if (eok) begin m_state = 1; m_lane = mask; m_pll = 1; end
      else begin m_lane = '0; m_pll = 0; end
      check(eok ? "R6 state after link-up" : "R5 back-out", 32'(dut_snap()), 32'(model_snap()));
      @(negedge clk);
      cmd_valid = 1'b0; pll_stable = 1'b0; lanes_stopped = 1'b0;
      repeat (2) @(negedge clk);
      check("R11 stray command ignored", {29'd0, rsp_ok, rsp_err, busy}, 0);
      check("R11 state kept after stray command", 32'(dut_snap()), 32'(model_snap()));
   endtask

   initial begin
      void'($urandom(32'h1d5a_0c37));
      do_reset();
      @(posedge clk); #1;
      check("R1 reset outputs", {17'd0, dut_snap(), busy, rsp_ok, rsp_err, fifo_ptr_rst, irq_clr}, 0);

      // directed corners
      do_cmd(0, 0, 0, 0, 0, "R3 lane count 0");
      do_cmd(0, 5, 0, 0, 0, "R3 lane count 5");
      do_cmd(0, 7, 0, 0, 0, "R3 lane count 7");
      do_cmd(2, 2, 0, 0, 0, "R9 HS transfer in initial");
      do_cmd(3, 2, 0, 0, 0, "R9 LP transfer in initial");
      do_cmd(1, 2, 0, 0, 0, "R8 HS clock in initial");
      do_cmd(4, 2, 0, 0, 0, "R10 enter in initial");
      do_cmd(6, 2, 0, 0, 0, "R12 op 6");
      do_cmd(7, 2, 0, 0, 0, "R12 op 7");
      do_cmd(0, 3, 0, PLLT, 0, "R5 PLL never stable");
      do_cmd(0, 3, 0, PLLT - 1, 0, "R5 PLL stable on last sample");
      do_reset();
      do_cmd(0, 2, 0, 4, STOPT, "R6 lanes never stop");
      do_cmd(0, 2, 0, 0, STOPT - 1, "R6 lanes stop on last sample");
      do_reset();
      do_cmd(0, 1, 0, 3, 5, "R4 link-up one lane");
      do_cmd(0, 4, 0, 0, 0, "R7 link-up in stop");
      do_cmd(2, 1, 0, 0, 0, "R9 HS transfer in stop");
      do_cmd(1, 1, 1, 0, 0, "R8 HS clock with bypass");
      do_cmd(1, 1, 0, 0, 0, "R8 HS clock in stop");
      do_cmd(3, 1, 0, 0, 0, "R9 LP transfer in HS");
      do_cmd(2, 1, 0, 0, 0, "R9 HS transfer in HS");
      do_cmd(5, 1, 0, 0, 0, "R10 exit outside ULP");
      do_cmd(4, 1, 0, 0, 0, "R10 enter from HS");
      do_cmd(3, 1, 0, 0, 0, "R9 LP transfer in ULP");
      do_cmd(1, 1, 0, 0, 0, "R8 HS clock in ULP");
      do_cmd(0, 1, 0, 0, 0, "R7 link-up in ULP");
      do_cmd(5, 1, 0, 0, 0, "R10 exit to stop");

      // constrained random stream
      for (int n = 0; n < 120; n++) begin
         int op, cnt, pd, ld;
         bit byp;
         if ($urandom % 10 == 0) do_reset();
         op  = (m_state == 0 && ($urandom % 2)) ? 0 : int'($urandom % 8);
         cnt = int'($urandom % 8);
         byp = ($urandom % 4 == 0);
         pd  = ($urandom % 12 == 0) ? PLLT : int'($urandom % 9);
         ld  = ($urandom % 12 == 0) ? STOPT + int'($urandom % 3) : int'($urandom % 9);
         do_cmd(op, cnt, byp, pd, ld, "R2 R11 random command");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule